// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt sources into two 8-bit local groups. Each group has a status input and a local mask register, and one bit position in each group is a cascade input. When the cascade bit of a group is pending, the source number is taken from a shared 8-bit mapped status vector instead. Each group gates that vector through its own mapped mask. Every cycle the block registers three things: a level request per group, an encoded source number with a valid flag per group, and a single selected top-level source.

Software controls the four mask registers through a small write port with separate set-bits and clear-bits operations, so each update is atomic. It reads the masks back through a combinational read port. Writes to a mapped mask also keep the matching cascade enable in the local mask up to date. The top-level arbiter chooses one source from a fixed, non-numeric priority order: the processor timer, then the two local levels, then bus error, then the pair of interval-timer lines.

Top module: `casc_intc`

## Requirements
- R1: A group's pending value is its status input ANDed with its local mask. The group's level output goes high one clock after that value becomes nonzero.
- R2: Within a group, the highest-numbered pending bit wins. The encoded number is the group base plus the bit index. The default bases are 8 for local group 0, 16 for local group 1, 24 for mapped group 0 and 32 for mapped group 1.
- R3: When nothing is pending for a group, its encoded number is 0 and its valid flag is low. The valid flag is high exactly when the number is nonzero.
- R4: When a group's cascade bit (bit 3 by default) is pending, the number comes from the mapped status ANDed with that group's mapped mask, using the mapped base. The other local bits are then ignored. If the mapped product is zero, the number is 0.
- R5: A set operation on a mapped mask with nonzero data sets those bits in the mapped mask. It also sets the cascade bit of the matching local mask.
- R6: A clear operation on a mapped mask clears the data bits in the mapped mask. The matching local cascade bit is cleared only if the mapped mask becomes zero; otherwise it is kept.
- R7: A set operation on a local mask never sets that mask's cascade bit. The other bits are set as written.
- R8: After reset, all four masks read zero, both numbers are 0, both valid flags and level outputs are low, and the selection code is 0.
- R9: The registered selection code is chosen in this priority order:
  - processor timer → 1;
  - local level 0 → 2;
  - local level 1 → 3;
  - bus error → 4;
  - either interval-timer line → 5;
  - none of these → 0.

  Only one code is output per cycle.
- R10: Write address 0 selects local mask 0, 1 selects local mask 1, 2 selects mapped mask 0 and 3 selects mapped mask 1. Operation 0 sets the data bits and 1 clears them. The read port returns the addressed mask with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat0_i | input | 8 | Local group 0 status, level-sensitive |
| stat1_i | input | 8 | Local group 1 status, level-sensitive |
| map_stat_i | input | 8 | Shared mapped status vector |
| cpu_tmr_i | input | 1 | Processor timer request |
| bus_err_i | input | 1 | Bus error request |
| pit_i | input | 2 | Interval-timer requests |
| wr_en_i | input | 1 | Mask write strobe |
| wr_addr_i | input | 2 | Mask select for writes |
| wr_op_i | input | 1 | 0 = set bits, 1 = clear bits |
| wr_data_i | input | 8 | Bit pattern to set or clear |
| rd_addr_i | input | 2 | Mask select for reads |
| rd_data_o | output | 8 | Addressed mask value |
| lvl0_o | output | 1 | Local level 0 request |
| lvl1_o | output | 1 | Local level 1 request |
| num0_o | output | 6 | Encoded source number, group 0 |
| vld0_o | output | 1 | Group 0 number valid |
| num1_o | output | 6 | Encoded source number, group 1 |
| vld1_o | output | 1 | Group 1 number valid |
| sel_o | output | 3 | Selected top-level source code |

## Verification
A mapped-mask clear that empties the mask can land in the same cycle as a pending cascade status. In that case the cascade enable drops while the resolver is still choosing between the mapped path and the local path. The bench provokes this by issuing the emptying clear while group 0 has both its cascade bit and a higher local bit pending. It then checks that the number registered on the write's own edge still comes from the mapped base. It also checks that the number on the next edge has fallen back to the local-group number of the higher bit.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CPU  = 3'd1,
        SEL_L0   = 3'd2,
        SEL_L1   = 3'd3,
        SEL_BUS  = 3'd4,
        SEL_PIT  = 3'd5
    } sel_e;

    typedef enum logic {
        OP_SET = 1'b0,
        OP_CLR = 1'b1
    } wr_op_e;

endpackage

// File: rtl/casc_prio_enc.sv
module casc_prio_enc #(
    parameter  int W     = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // later (higher) bits overwrite earlier ones: highest index wins
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |vec_i;
    end

endmodule

// File: rtl/casc_grp_res.sv
module casc_grp_res #(
    parameter int W        = 8,
    parameter int NUM_W    = 6,
    parameter int CASC_BIT = 3,
    parameter int LBASE    = 8,
    parameter int MBASE    = 24
) (
    input  logic [W-1:0]     stat_i,
    input  logic [W-1:0]     lmask_i,
    input  logic [W-1:0]     map_stat_i,
    input  logic [W-1:0]     mmask_i,
    output logic [NUM_W-1:0] num_o,
    output logic             lvl_o
);

    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     lpend, mpend;
    logic [IDX_W-1:0] lidx, midx;
    logic             lany, many;

    assign lpend = stat_i & lmask_i;
    assign mpend = map_stat_i & mmask_i;

    casc_prio_enc #(.W(W)) i_lenc (.vec_i(lpend), .idx_o(lidx), .any_o(lany));
    casc_prio_enc #(.W(W)) i_menc (.vec_i(mpend), .idx_o(midx), .any_o(many));

    always_comb begin
        if (lpend[CASC_BIT]) begin
            num_o = many ? NUM_W'(MBASE) + NUM_W'(midx) : '0;
        end else begin
            num_o = lany ? NUM_W'(LBASE) + NUM_W'(lidx) : '0;
        end
        lvl_o = lany;
    end

endmodule

// File: rtl/casc_mask_regs.sv
module casc_mask_regs
    import casc_intc_pkg::*;
#(
    parameter int W        = 8,
    parameter int CASC_BIT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic                wr_op_i,
    input  logic [W-1:0]        wr_data_i,
    output logic [1:0][W-1:0]   lmask_o,
    output logic [1:0][W-1:0]   mmask_o
);

    localparam logic [W-1:0] CASC_ONE = W'(1) << CASC_BIT;

    typedef struct packed {
        logic [1:0][W-1:0] lm;
        logic [1:0][W-1:0] mm;
    } mregs_t;

    mregs_t r_d, r_q;
    logic   grp;

    always_comb begin
        r_d = r_q;
        grp = wr_addr_i[0];
        if (wr_en_i) begin
            if (!wr_addr_i[1]) begin
                if (wr_op_i == OP_SET) r_d.lm[grp] = r_q.lm[grp] | (wr_data_i & ~CASC_ONE);
                else                   r_d.lm[grp] = r_q.lm[grp] & ~wr_data_i;
            end else begin
                if (wr_op_i == OP_SET) begin
                    r_d.mm[grp] = r_q.mm[grp] | wr_data_i;
                    if (wr_data_i != '0) r_d.lm[grp] = r_d.lm[grp] | CASC_ONE;
                end else begin
                    r_d.mm[grp] = r_q.mm[grp] & ~wr_data_i;
                    if (r_d.mm[grp] == '0) r_d.lm[grp] = r_d.lm[grp] & ~CASC_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lmask_o = r_q.lm;
    assign mmask_o = r_q.mm;

    for (genvar g = 0; g < 2; g++) begin : g_chk
        p_map_set_casc_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == {1'b1, 1'(g)} && wr_op_i == OP_SET && wr_data_i != '0)
            |=> lmask_o[g][CASC_BIT]);
        p_map_clr_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == {1'b1, 1'(g)} && wr_op_i == OP_CLR && (mmask_o[g] & ~wr_data_i) == '0)
            |=> (!lmask_o[g][CASC_BIT] && mmask_o[g] == '0));
        p_plain_set_no_casc_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == {1'b0, 1'(g)} && wr_op_i == OP_SET && !lmask_o[g][CASC_BIT])
            |=> !lmask_o[g][CASC_BIT]);
    end

endmodule

// File: rtl/casc_intc.sv
module casc_intc
    import casc_intc_pkg::*;
#(
    parameter  int W        = 8,
    parameter  int CASC_BIT = 3,
    parameter  int L0_BASE  = 8,
    parameter  int L1_BASE  = 16,
    parameter  int M0_BASE  = 24,
    parameter  int M1_BASE  = 32,
    localparam int NUM_W    = $clog2(M1_BASE + W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     stat0_i,
    input  logic [W-1:0]     stat1_i,
    input  logic [W-1:0]     map_stat_i,
    input  logic             cpu_tmr_i,
    input  logic             bus_err_i,
    input  logic [1:0]       pit_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic             wr_op_i,
    input  logic [W-1:0]     wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [W-1:0]     rd_data_o,
    output logic             lvl0_o,
    output logic             lvl1_o,
    output logic [NUM_W-1:0] num0_o,
    output logic             vld0_o,
    output logic [NUM_W-1:0] num1_o,
    output logic             vld1_o,
    output logic [2:0]       sel_o
);

    localparam int LB [2] = '{L0_BASE, L1_BASE};
    localparam int MB [2] = '{M0_BASE, M1_BASE};

    typedef struct packed {
        logic [1:0][NUM_W-1:0] num;
        logic [1:0]            vld;
        logic [1:0]            lvl;
        sel_e                  sel;
    } outs_t;

    logic [1:0][W-1:0]     lmask, mmask;
    logic [1:0][W-1:0]     stat;
    logic [1:0][NUM_W-1:0] gnum;
    logic [1:0]            glvl;
    outs_t                 o_d, o_q;

    assign stat = {stat1_i, stat0_i};

    casc_mask_regs #(.W(W), .CASC_BIT(CASC_BIT)) i_mregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_op_i   (wr_op_i),
        .wr_data_i (wr_data_i),
        .lmask_o   (lmask),
        .mmask_o   (mmask)
    );

    for (genvar g = 0; g < 2; g++) begin : g_grp
        casc_grp_res #(
            .W(W), .NUM_W(NUM_W), .CASC_BIT(CASC_BIT), .LBASE(LB[g]), .MBASE(MB[g])
        ) i_res (
            .stat_i     (stat[g]),
            .lmask_i    (lmask[g]),
            .map_stat_i (map_stat_i),
            .mmask_i    (mmask[g]),
            .num_o      (gnum[g]),
            .lvl_o      (glvl[g])
        );
    end

    always_comb begin
        o_d.num = gnum;
        o_d.vld = {gnum[1] != '0, gnum[0] != '0};
        o_d.lvl = glvl;
        if      (cpu_tmr_i) o_d.sel = SEL_CPU;
        else if (glvl[0])   o_d.sel = SEL_L0;
        else if (glvl[1])   o_d.sel = SEL_L1;
        else if (bus_err_i) o_d.sel = SEL_BUS;
        else if (|pit_i)    o_d.sel = SEL_PIT;
        else                o_d.sel = SEL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    always_comb begin
        unique case (rd_addr_i)
            2'd0:    rd_data_o = lmask[0];
            2'd1:    rd_data_o = lmask[1];
            2'd2:    rd_data_o = mmask[0];
            default: rd_data_o = mmask[1];
        endcase
    end

    assign num0_o = o_q.num[0];
    assign num1_o = o_q.num[1];
    assign vld0_o = o_q.vld[0];
    assign vld1_o = o_q.vld[1];
    assign lvl0_o = o_q.lvl[0];
    assign lvl1_o = o_q.lvl[1];
    assign sel_o  = o_q.sel;

    p_vld_num0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld0_o == (num0_o != '0));
    p_vld_num1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld1_o == (num1_o != '0));
    p_timer_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tmr_i |=> sel_o == SEL_CPU);
    p_local0_over_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_tmr_i && (stat0_i & lmask[0]) != '0) |=> sel_o == SEL_L0);
    p_lvl_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat1_i & lmask[1]) != '0) |=> lvl1_o);

endmodule

// File: tb/test_casc_intc.sv
module test_casc_intc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stat0 = '0, stat1 = '0, mstat = '0;
    logic       cpu_tmr = 1'b0, bus_err = 1'b0;
    logic [1:0] pit = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic       wr_op = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       lvl0, lvl1, vld0, vld1;
    logic [5:0] num0, num1;
    logic [2:0] sel;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    casc_intc i_casc_intc (
        .clk(clk), .rst_n(rst_n),
        .stat0_i(stat0), .stat1_i(stat1), .map_stat_i(mstat),
        .cpu_tmr_i(cpu_tmr), .bus_err_i(bus_err), .pit_i(pit),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_op_i(wr_op), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .lvl0_o(lvl0), .lvl1_o(lvl1),
        .num0_o(num0), .vld0_o(vld0), .num1_o(num1), .vld1_o(vld1),
        .sel_o(sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic op, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_op = op; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 4; a++) rd_chk("R8 mask zero", 2'(a), 0);
        chk("R8 num0", num0, 0); chk("R8 vld0", vld0, 0);
        chk("R8 num1", num1, 0); chk("R8 vld1", vld1, 0);
        chk("R8 lvl0", lvl0, 0); chk("R8 sel", sel, 0);
    endtask

    task automatic t_local();
        wr(2'd0, 1'b0, 8'hF7);
        rd_chk("R10 set lm0", 2'd0, 8'hF7);
        stat0 = 8'h25; step();
        chk("R2 num0 bit5", num0, 13); chk("R1 lvl0", lvl0, 1); chk("R3 vld0", vld0, 1);
        stat0 = 8'h01; step();
        chk("R2 num0 bit0", num0, 8);
        wr(2'd1, 1'b0, 8'h41); stat1 = 8'h41; step();
        chk("R2 num1 bit6", num1, 22); chk("R1 lvl1", lvl1, 1);
        wr(2'd0, 1'b1, 8'h80);
        rd_chk("R10 clr lm0", 2'd0, 8'h77);
        stat0 = 8'h80; step();
        chk("R3 masked num0", num0, 0); chk("R3 masked vld0", vld0, 0); chk("R1 masked lvl0", lvl0, 0);
        wr(2'd0, 1'b0, 8'h80);
    endtask

    task automatic t_plain_casc();
        wr(2'd0, 1'b0, 8'h08);
        rd_chk("R7 casc not set", 2'd0, 8'hF7);
        stat0 = 8'h08; mstat = 8'hFF; step();
        chk("R7 casc not pending vld0", vld0, 0); chk("R7 lvl0", lvl0, 0);
    endtask

    task automatic t_mapped();
        wr(2'd2, 1'b0, 8'h12);
        rd_chk("R5 lm0 casc", 2'd0, 8'hFF); rd_chk("R5 mm0", 2'd2, 8'h12);
        stat0 = 8'h88; mstat = 8'h13; step();
        chk("R4 num0 mapped", num0, 28); chk("R4 vld0", vld0, 1);
        wr(2'd1, 1'b1, 8'hFF);
        wr(2'd3, 1'b0, 8'h01);
        rd_chk("R5 lm1 casc", 2'd1, 8'h08);
        stat1 = 8'h08; step();
        chk("R4 num1 mapped", num1, 32);
        mstat = 8'h00; step();
        chk("R4 empty map num0", num0, 0); chk("R4 empty map vld0", vld0, 0);
        chk("R4 empty map num1", num1, 0); chk("R1 casc lvl0", lvl0, 1);
        mstat = 8'h13; step();
    endtask

    task automatic t_unmap();
        wr(2'd2, 1'b1, 8'h02);
        rd_chk("R6 mm0 partial", 2'd2, 8'h10); rd_chk("R6 casc kept", 2'd0, 8'hFF);
        step();
        chk("R6 num0 still mapped", num0, 28);
        // emptying clear in the same cycle as a pending cascade status
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_op = 1'b1; wr_data = 8'h10;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 old mask edge", num0, 28);
        @(negedge clk);
        chk("R6 fallback num0", num0, 15);
        rd_chk("R6 casc cleared", 2'd0, 8'hF7); rd_chk("R6 mm0 empty", 2'd2, 0);
    endtask

    task automatic t_arb();
        cpu_tmr = 1'b1; bus_err = 1'b1; pit = 2'b11; step();
        chk("R9 cpu first", sel, 1);
        cpu_tmr = 1'b0; step();
        chk("R9 local0", sel, 2);
        stat0 = 8'h00; step();
        chk("R9 local1", sel, 3);
        stat1 = 8'h00; step();
        chk("R9 bus", sel, 4);
        bus_err = 1'b0; pit = 2'b01; step();
        chk("R9 pit0", sel, 5);
        pit = 2'b10; step();
        chk("R9 pit1", sel, 5);
        pit = 2'b00; step();
        chk("R9 none", sel, 0);
    endtask

    initial begin
        #(8 * 100000);
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_local();
        t_plain_casc();
        t_mapped();
        t_unmap();
        t_arb();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule